// File: doc/BRIEF.md
# Raster Line Interrupt Generator

This block raises a periodic maskable interrupt request for a processor by counting display lines. Each falling edge of the horizontal sync input advances a six-bit line counter; after fifty-two lines the counter returns to zero and the request goes up. The request then stays high until the processor acknowledges it, and the counter keeps running while the request waits. With one line every 64 µs this gives 300 requests per second.

An acknowledge clears the request and also clears the 32-weight bit of the counter, so the next request can come no sooner than 32 lines later. A vertical sync rising edge starts a two-line wait. At the end of the wait the block decides from the counter value whether to raise a request, and it restarts the count from zero either way. This keeps the interrupt pattern in step with the frame. Software can zero the counter and drop any pending request at any time through a clear strobe.

Both sync inputs may be asynchronous. They pass through a synchroniser, and their edges are detected in the system clock domain.

Top module: `raster_irq_gen`

## Requirements
- R1: The line counter advances by exactly one for each falling edge of `hsync_in`, however long the line stays low or high.
- R2: When the counter would reach 52, it returns to 0 and `irq` is set to 1.
- R3: Once set, `irq` stays at 1 until `int_ack` or `sw_clear` is applied, and the counter keeps advancing while it waits.
- R4: A one-cycle `int_ack` pulse sets `irq` to 0 and clears bit 5 (weight 32) of the counter. Lower bits are kept, so a counter at 40 continues from 8.
- R5: A rising edge of `vsync_in` arms a two-line wait. On the second `hsync_in` falling edge after it, if the counter value before that edge is below 32, `irq` is set to 1 and the counter returns to 0.
- R6: At the same decision point, if the counter value is 32 or more, no request is raised and the counter returns to 0.
- R7: A `sw_clear` pulse sets the counter to 0 and `irq` to 0. When it comes together with `int_ack`, the combined result is the same.
- R8: A new `vsync_in` rising edge during the wait restarts the two-line wait. Holding `vsync_in` high has no further effect after the decision.
- R9: A sync edge at the inputs shows on `irq` at the third rising clock edge. `int_ack` and `sw_clear` act at the first rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync, active high, asynchronous |
| vsync_in | input | 1 | Vertical sync, active high, asynchronous |
| int_ack | input | 1 | Processor interrupt acknowledge strobe |
| sw_clear | input | 1 | Software strobe that zeroes the counter |
| irq | output | 1 | Interrupt request, held until acknowledged |

## Verification
A falling edge of `hsync_in` passes through two synchroniser flops and one edge flop, so its effect on `irq` appears at the third rising clock edge. The acknowledge and clear strobes act at the next edge. The bench drives every input on the falling clock edge and keeps each line low for at least four clock periods. It samples `irq` on a falling edge after the line task returns, which is always later than the third edge. Counter contents are inferred only from the line on which the next request appears, and each check counts lines from a known zero point.

// File: rtl/rli_pkg.sv
package rli_pkg;

   // Action chosen for the line counter in a given cycle
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_STEP   = 2'd1,
      ACT_WRAP   = 2'd2,
      ACT_DECIDE = 2'd3
   } rli_act_e;

endpackage

// File: rtl/rli_sync_edge.sv
module rli_sync_edge #(
   parameter int unsigned N         = 2,
   parameter int unsigned STAGES    = 2,
   parameter logic [N-1:0] FALL_SEL = '0   // 1: falling edge, 0: rising edge
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] edge_p
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rli_sync_edge: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_ch
      logic [STAGES:0] chain;

      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-1:0], din[i]};
      end

      if (FALL_SEL[i]) begin : g_fall
         assign edge_p[i] = chain[STAGES] & ~chain[STAGES-1];
      end else begin : g_rise
         assign edge_p[i] = chain[STAGES-1] & ~chain[STAGES];
      end

      // R1: an edge pulse lasts a single cycle
      a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         edge_p[i] |=> !edge_p[i]);
   end

endmodule

// File: rtl/rli_vs_window.sv
module rli_vs_window #(
   parameter int unsigned DELAY_LINES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vs_rise,
   input  logic hs_fall,
   output logic decide
);

   localparam int unsigned VW = $clog2(DELAY_LINES + 1);
   localparam logic [VW-1:0] LAST = VW'(DELAY_LINES - 1);

   if (DELAY_LINES < 1) begin : g_bad_delay
      $error("rli_vs_window: DELAY_LINES must be at least 1");
   end

   logic          armed_q;
   logic [VW-1:0] seen_q;

   assign decide = armed_q && hs_fall && !vs_rise && (seen_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         seen_q  <= '0;
      end else if (vs_rise) begin
         armed_q <= 1'b1;
         seen_q  <= '0;
      end else if (armed_q && hs_fall) begin
         if (seen_q == LAST) begin
            armed_q <= 1'b0;
            seen_q  <= '0;
         end else begin
            seen_q  <= seen_q + 1'b1;
         end
      end
   end

   // R5: after the decision the wait is closed unless re-armed
   a_r5_decide_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      decide |=> !armed_q);

   // R8: a vsync rising edge always leaves the wait armed
   a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise |=> (armed_q && seen_q == '0));

endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen #(
   parameter int unsigned CNT_W       = 6,
   parameter int unsigned WRAP        = 52,
   parameter int unsigned GUARD_BIT   = 5,
   parameter int unsigned DELAY_LINES = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_in,
   input  logic vsync_in,
   input  logic int_ack,
   input  logic sw_clear,
   output logic irq
);
   import rli_pkg::*;

   localparam logic [CNT_W-1:0] LAST   = CNT_W'(WRAP - 1);
   localparam logic [CNT_W-1:0] THRESH = CNT_W'(1 << GUARD_BIT);

   if (WRAP < 2 || WRAP > (1 << CNT_W)) begin : g_bad_wrap
      $error("raster_irq_gen: WRAP must fit in CNT_W bits");
   end
   if (GUARD_BIT >= CNT_W) begin : g_bad_guard
      $error("raster_irq_gen: GUARD_BIT must lie inside the counter");
   end

   logic [1:0] edges;
   logic       hs_fall, vs_rise, decide;

   rli_sync_edge #(
      .N        (2),
      .STAGES   (SYNC_STAGES),
      .FALL_SEL (2'b01)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    ({vsync_in, hsync_in}),
      .edge_p (edges)
   );

   assign hs_fall = edges[0];
   assign vs_rise = edges[1];

   rli_vs_window #(
      .DELAY_LINES (DELAY_LINES)
   ) u_vsw (
      .clk     (clk),
      .rst_n   (rst_n),
      .vs_rise (vs_rise),
      .hs_fall (hs_fall),
      .decide  (decide)
   );

   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_a;
   logic             irq_q, irq_d, irq_a;
   rli_act_e         act;

   always_comb begin
      cnt_a = cnt_q;
      irq_a = irq_q;
      if (int_ack) begin
         cnt_a[GUARD_BIT] = 1'b0;
         irq_a            = 1'b0;
      end
      if (!hs_fall)          act = ACT_HOLD;
      else if (decide)       act = ACT_DECIDE;
      else if (cnt_a == LAST) act = ACT_WRAP;
      else                   act = ACT_STEP;
   end

   always_comb begin
      cnt_d = cnt_a;
      irq_d = irq_a;
      unique case (act)
         ACT_HOLD:   ;
         ACT_STEP:   cnt_d = cnt_a + 1'b1;
         ACT_WRAP: begin
            cnt_d = '0;
            irq_d = 1'b1;
         end
         ACT_DECIDE: begin
            cnt_d = '0;
            if (cnt_a < THRESH) irq_d = 1'b1;
         end
         default:    ;
      endcase
      if (sw_clear) begin
         cnt_d = '0;
         irq_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         irq_q <= irq_d;
      end
   end

   assign irq = irq_q;

   // R2: the counter never leaves its range
   a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R3: a pending request is held without ack or clear
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !int_ack && !sw_clear) |=> irq);

   // R4: acknowledge with no line edge drops the request and bit 5
   a_r4_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !hs_fall) |=> (!irq && !cnt_q[GUARD_BIT]));

   // R7: a clear empties counter and request
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clear |=> (!irq && cnt_q == '0));

endmodule

// File: tb/raster_irq_gen_test.sv
module raster_irq_gen_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_in = 1'b0;
   logic vsync_in = 1'b0;
   logic int_ack = 1'b0;
   logic sw_clear = 1'b0;
   logic irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   raster_irq_gen uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .hsync_in (hsync_in),
      .vsync_in (vsync_in),
      .int_ack  (int_ack),
      .sw_clear (sw_clear),
      .irq      (irq)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: irq actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one display line: high then low; R9 latency is covered by low_len >= 4
   task automatic line(input int low_len = 5);
      hsync_in = 1'b1;
      idle(3);
      hsync_in = 1'b0;
      idle(low_len);
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) line();
   endtask

   task automatic pulse_ack();
      int_ack = 1'b1;
      idle(1);
      int_ack = 1'b0;
   endtask

   task automatic pulse_clear(input bit with_ack);
      sw_clear = 1'b1;
      int_ack  = with_ack;
      idle(1);
      sw_clear = 1'b0;
      int_ack  = 1'b0;
   endtask

   task automatic set_vsync(input logic v);
      vsync_in = v;
      idle(4);
   endtask

   task automatic t_reset();
      check("R9 reset", irq, 1'b0);
   endtask

   task automatic t_count_wrap();
      for (int i = 0; i < 51; i++) line((i % 7 == 0) ? 20 : 5);
      check("R1 no irq after 51 lines", irq, 1'b0);
      line();
      check("R2 irq at line 52", irq, 1'b1);
   endtask

   task automatic t_pending();
      lines(10);
      check("R3 irq held while counting", irq, 1'b1);
      pulse_ack();
      check("R4 ack drops irq", irq, 1'b0);
      lines(41);
      check("R3 counter kept running (41)", irq, 1'b0);
      line();
      check("R3 counter kept running (42)", irq, 1'b1);
   endtask

   task automatic t_guard_bit();
      lines(40);
      check("R3 irq held 40 lines", irq, 1'b1);
      pulse_ack();
      lines(43);
      check("R4 bit5 cleared, 43 lines", irq, 1'b0);
      line();
      check("R4 bit5 cleared, 44 lines", irq, 1'b1);
   endtask

   task automatic t_clear();
      lines(20);
      pulse_clear(1'b0);
      check("R7 clear drops irq", irq, 1'b0);
      lines(51);
      check("R7 counter zeroed, 51", irq, 1'b0);
      line();
      check("R7 counter zeroed, 52", irq, 1'b1);
      lines(5);
      pulse_clear(1'b1);
      check("R7 clear with ack", irq, 1'b0);
      lines(51);
      check("R7 clear with ack, 51", irq, 1'b0);
      line();
      check("R7 clear with ack, 52", irq, 1'b1);
      pulse_ack();
   endtask

   task automatic t_vsync_low();
      pulse_clear(1'b0);
      lines(10);
      set_vsync(1'b1);
      line();
      check("R5 no irq after first wait line", irq, 1'b0);
      line();
      check("R5 irq at decision below 32", irq, 1'b1);
      set_vsync(1'b0);
      pulse_ack();
      lines(51);
      check("R5 counter reset, 51", irq, 1'b0);
      line();
      check("R5 counter reset, 52", irq, 1'b1);
      pulse_ack();
   endtask

   task automatic t_vsync_high();
      lines(40);
      check("R6 no irq at 40", irq, 1'b0);
      set_vsync(1'b1);
      lines(2);
      check("R6 no irq at decision 32 or more", irq, 1'b0);
      lines(51);
      check("R8 held vsync ignored, 51", irq, 1'b0);
      line();
      check("R6 counter reset, 52", irq, 1'b1);
      set_vsync(1'b0);
      pulse_ack();
   endtask

   task automatic t_rearm();
      pulse_clear(1'b0);
      lines(5);
      set_vsync(1'b1);
      line();
      set_vsync(1'b0);
      set_vsync(1'b1);
      line();
      check("R8 rearmed wait not done", irq, 1'b0);
      line();
      check("R8 decision after rearm", irq, 1'b1);
      set_vsync(1'b0);
      pulse_ack();
      lines(51);
      check("R8 counter reset after rearm, 51", irq, 1'b0);
      line();
      check("R8 counter reset after rearm, 52", irq, 1'b1);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_count_wrap();
      t_pending();
      t_guard_bit();
      t_clear();
      t_vsync_low();
      t_vsync_high();
      t_rearm();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 150000; i++) begin
         @(negedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule